// File: doc/BRIEF.md
# Port-Write Receive Interrupt Controller

This block sits behind the receive path of a maintenance engine and owns a single-entry store for an incoming port-write payload. A port-write arrives as one beat on a valid/ready stream that carries the whole payload. The block keeps that payload when reception is switched on and the store is empty. Otherwise it throws the port-write away. Each outcome, and every pulse on the external error strobe, raises its own sticky flag in a status register. Software clears a flag by writing 1 to it.

Software reaches the status register, an interrupt-mask register and the stored payload words through a simple register port. Reads on that port return data one cycle later. Reading the last payload word frees the store for the next port-write. A level interrupt is raised while any flag is set together with its mask bit.

The stream input never exerts back-pressure. The ready signal stays high from the first clock edge after reset is released. A port-write that cannot be kept is consumed and counted as dropped, never stalled. The sender may therefore treat every beat with valid high as accepted in the cycle it is presented.

Top module: `pw_rx_irq_ctrl`

## Requirements
- R1: After reset the status register, the mask register, the interrupt output and the read data are all 0, and the payload store is empty.
- R2: A port-write beat accepted while the receive-enable input is 1 and the store is empty is kept, and status bit 4 (stored) is 1 from the next clock edge.
- R3: A port-write beat accepted while the receive-enable input is 0 is discarded, and status bit 5 (dropped) is 1 from the next clock edge.
- R4: A port-write beat accepted while the store still holds an unread payload is discarded, sets status bit 5, and leaves the stored payload unchanged.
- R5: A read of the last payload word (index WORDS-1) empties the store. Reads of other words do not empty it.
- R6: A pulse on the error strobe sets status bit 6 (error) from the next clock edge.
- R7: Writing the status register clears each of bits 6, 5 and 4 whose write-data bit is 1, and leaves bits written with 0 unchanged.
- R8: When a flag's set event and a write-1 clear of that flag fall in the same cycle, the flag ends up set.
- R9: The status register lives at byte address 0x10080 and the mask register at 0x10084. Both use bits 6, 5 and 4 only. All other bits read 0 and ignore writes.
- R10: The interrupt output is 1 exactly when some status bit and the mask bit in the same position are both 1. It follows flag and mask changes from the same clock edge.
- R11: A read returns its data on the read-data output together with a one-cycle read-valid pulse, one clock edge after the request. Payload word i reads at 0x10090 + 4*i. Writes to payload addresses are ignored, and unmapped addresses read 0.
- R12: The stream ready output is 1 in every cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pw_valid | input | 1 | Port-write beat valid |
| pw_ready | output | 1 | Port-write beat ready (never back-pressures) |
| pw_data | input | WORDS*DATA_W | Whole port-write payload, word 0 in the low bits |
| pw_rx_enable | input | 1 | Receive-enable bit from the receive control register |
| pw_err | input | 1 | Error strobe from the receive path |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 20 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rvalid | output | 1 | Read data valid pulse |
| irq | output | 1 | Level interrupt |

## Verification
Flags, the store state and the interrupt output all change on the clock edge that samples the port-write beat, error pulse or register write. Read data appears one edge after the read request. The bench therefore drives every stimulus on a falling edge and looks at results on the next falling edge. Interrupt checks are taken immediately after the driving task returns. Read results come from a scoreboard queue: the driver pushes the expected word when it issues the read, and a monitor on the falling edge pops and compares that word once read-valid appears. This keeps every comparison at its due cycle without fixed delays in the checks.

// File: rtl/pwirq_pkg.sv
package pwirq_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 20;

  localparam logic [ADDR_W-1:0] STATUS_ADDR = 20'h10080;
  localparam logic [ADDR_W-1:0] IRQEN_ADDR  = 20'h10084;
  localparam logic [ADDR_W-1:0] DATA_BASE   = 20'h10090;

  // flag index 0..2 maps to register bit FLAG_LO+index
  localparam int unsigned FLAG_LO  = 4;
  localparam int unsigned N_FLAGS  = 3;
  localparam int unsigned IDX_STORED = 0;
  localparam int unsigned IDX_DROP   = 1;
  localparam int unsigned IDX_ERR    = 2;

  typedef struct packed {
    logic err;
    logic drop;
    logic stored;
  } pw_evt_t;
endpackage

// File: rtl/pwirq_buffer.sv
module pwirq_buffer #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WORDS*DATA_W-1:0] in_data,
  input  logic                    rx_enable,
  input  logic                    rd_word_en,
  input  logic [IDX_W-1:0]        rd_word_idx,
  output logic [DATA_W-1:0]       word_out,
  output logic                    stored_evt,
  output logic                    drop_evt
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic                    ready_q;
  logic                    full_q;
  logic                    in_fire;
  logic                    accept;
  logic                    drain;
  logic [DATA_W-1:0]       words_q [WORDS];
  logic [WORDS*DATA_W-1:0] payload_flat;

  assign in_ready = ready_q;
  assign in_fire  = in_valid & ready_q;
  assign accept   = in_fire & rx_enable & ~full_q;
  assign drain    = rd_word_en & (rd_word_idx == LAST_IDX);

  assign stored_evt = accept;
  assign drop_evt   = in_fire & ~accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (accept)     full_q <= 1'b1;
      else if (drain) full_q <= 1'b0;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)      words_q[w] <= '0;
      else if (accept) words_q[w] <= in_data[w*DATA_W +: DATA_W];
    end
    assign payload_flat[w*DATA_W +: DATA_W] = words_q[w];
  end

  assign word_out = words_q[rd_word_idx];

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && rx_enable && !full_q) |=> full_q);

  assert_keep_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && full_q) |=> $stable(payload_flat));

  assert_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word_en && rd_word_idx == LAST_IDX && full_q) |=> !full_q);

  assert_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);
endmodule

// File: rtl/pwirq_status.sv
module pwirq_status
  import pwirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  pw_evt_t          evt,
  input  logic             wr_status,
  input  logic             wr_irqen,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] status_word,
  output logic [REG_W-1:0] irqen_word,
  output logic             irq
);
  logic [N_FLAGS-1:0] flags_q;
  logic [N_FLAGS-1:0] en_q;
  logic [N_FLAGS-1:0] set_vec;
  logic [N_FLAGS-1:0] wbit;

  assign set_vec = {evt.err, evt.drop, evt.stored};

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    assign wbit[i] = |(wdata & (REG_W'(1) << (FLAG_LO + i)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags_q[i] <= 1'b0;
        en_q[i]    <= 1'b0;
      end else begin
        // a set in the same cycle as a clear takes priority
        flags_q[i] <= set_vec[i] | (flags_q[i] & ~(wr_status & wbit[i]));
        if (wr_irqen) en_q[i] <= wbit[i];
      end
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flags_q[i]);

    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && wbit[i] && !set_vec[i]) |=> !flags_q[i]);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !(wr_status && wbit[i])) |=> flags_q[i]);
  end

  assign status_word = REG_W'(flags_q) << FLAG_LO;
  assign irqen_word  = REG_W'(en_q) << FLAG_LO;
  assign irq         = |(flags_q & en_q);

  assert_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt.err |=> status_word[FLAG_LO + IDX_ERR]);
endmodule

// File: rtl/pwirq_regif.sv
module pwirq_regif
  import pwirq_pkg::*;
#(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  status_word,
  input  logic [REG_W-1:0]  irqen_word,
  input  logic [DATA_W-1:0] data_word,
  output logic              wr_status,
  output logic              wr_irqen,
  output logic              rd_word_en,
  output logic [IDX_W-1:0]  rd_word_idx,
  output logic [REG_W-1:0]  rdata,
  output logic              rvalid
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(WORDS * 4);

  logic [ADDR_W-1:0] off;
  logic              hit_status;
  logic              hit_irqen;
  logic              hit_data;
  logic [REG_W-1:0]  rd_mux;
  logic [REG_W-1:0]  rdata_q;
  logic              rvalid_q;

  assign off        = reg_addr - DATA_BASE;
  assign hit_status = (reg_addr == STATUS_ADDR);
  assign hit_irqen  = (reg_addr == IRQEN_ADDR);
  assign hit_data   = (reg_addr >= DATA_BASE) && (off < SPAN) && (off[1:0] == 2'b00);

  assign wr_status   = reg_wr & hit_status;
  assign wr_irqen    = reg_wr & hit_irqen;
  assign rd_word_en  = reg_rd & hit_data;
  assign rd_word_idx = off[IDX_W+1:2];

  always_comb begin
    rd_mux = '0;
    if (hit_status)     rd_mux = status_word;
    else if (hit_irqen) rd_mux = irqen_word;
    else if (hit_data)  rd_mux = REG_W'(data_word);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_rd;
      if (reg_rd) rdata_q <= rd_mux;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rvalid);

  assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !rvalid);
endmodule

// File: rtl/pw_rx_irq_ctrl.sv
module pw_rx_irq_ctrl
  import pwirq_pkg::*;
#(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pw_valid,
  output logic                    pw_ready,
  input  logic [WORDS*DATA_W-1:0] pw_data,
  input  logic                    pw_rx_enable,
  input  logic                    pw_err,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [19:0]             reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic                    reg_rvalid,
  output logic                    irq
);
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  pw_evt_t           evt;
  logic              stored_evt;
  logic              drop_evt;
  logic              wr_status;
  logic              wr_irqen;
  logic              rd_word_en;
  logic [IDX_W-1:0]  rd_word_idx;
  logic [DATA_W-1:0] data_word;
  logic [REG_W-1:0]  status_word;
  logic [REG_W-1:0]  irqen_word;

  pwirq_buffer #(.WORDS(WORDS), .DATA_W(DATA_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (pw_valid),
    .in_ready   (pw_ready),
    .in_data    (pw_data),
    .rx_enable  (pw_rx_enable),
    .rd_word_en (rd_word_en),
    .rd_word_idx(rd_word_idx),
    .word_out   (data_word),
    .stored_evt (stored_evt),
    .drop_evt   (drop_evt)
  );

  assign evt.stored = stored_evt;
  assign evt.drop   = drop_evt;
  assign evt.err    = pw_err;

  pwirq_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt),
    .wr_status  (wr_status),
    .wr_irqen   (wr_irqen),
    .wdata      (reg_wdata),
    .status_word(status_word),
    .irqen_word (irqen_word),
    .irq        (irq)
  );

  pwirq_regif #(.WORDS(WORDS), .DATA_W(DATA_W)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .status_word(status_word),
    .irqen_word (irqen_word),
    .data_word  (data_word),
    .wr_status  (wr_status),
    .wr_irqen   (wr_irqen),
    .rd_word_en (rd_word_en),
    .rd_word_idx(rd_word_idx),
    .rdata      (reg_rdata),
    .rvalid     (reg_rvalid)
  );

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status_word & irqen_word) != '0));

  assert_drop_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_valid && pw_ready && !pw_rx_enable) |=> status_word[FLAG_LO + IDX_DROP]);
endmodule

// File: tb/pw_rx_irq_ctrl_tb.sv
module pw_rx_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS  = 4;
  localparam int DATA_W = 32;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    pw_valid = 1'b0;
  logic                    pw_ready;
  logic [WORDS*DATA_W-1:0] pw_data = '0;
  logic                    pw_rx_enable = 1'b0;
  logic                    pw_err = 1'b0;
  logic                    reg_wr = 1'b0;
  logic                    reg_rd = 1'b0;
  logic [19:0]             reg_addr = '0;
  logic [31:0]             reg_wdata = '0;
  logic [31:0]             reg_rdata;
  logic                    reg_rvalid;
  logic                    irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_rx_irq_ctrl #(.WORDS(WORDS), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pw_valid(pw_valid), .pw_ready(pw_ready),
    .pw_data(pw_data), .pw_rx_enable(pw_rx_enable), .pw_err(pw_err),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .irq(irq)
  );

  localparam logic [19:0] A_STAT = 20'h10080;
  localparam logic [19:0] A_IEN  = 20'h10084;
  localparam logic [19:0] A_DATA = 20'h10090;

  // scoreboard monitor: compares each read result in the cycle it appears
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11: unexpected read data %h", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        tests++;
        if (reg_rdata !== e) begin
          fails++;
          $display("FAIL %s: read got %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [19:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic send_pw(input logic [WORDS*DATA_W-1:0] d);
    @(negedge clk);
    pw_valid = 1'b1; pw_data = d;
    @(negedge clk);
    pw_valid = 1'b0;
    chk(pw_ready, 1'b1, "R12 ready");
  endtask

  function automatic logic [31:0] wd(input logic [WORDS*DATA_W-1:0] d, input int i);
    return d[i*DATA_W +: DATA_W];
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [WORDS*DATA_W-1:0] pa, pb, pc;
    pa = 128'hA3A3A3A3_A2A2A2A2_A1A1A1A1_A0A0A0A0;
    pb = 128'hB3B3B3B3_B2B2B2B2_B1B1B1B1_B0B0B0B0;
    pc = 128'hC3C3C3C3_C2C2C2C2_C1C1C1C1_C0C0C0C0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(irq, 1'b0, "R1 irq");
    chk(reg_rdata == 32'h0, 1'b1, "R1 rdata");
    chk(pw_ready, 1'b1, "R12 ready");
    do_read(A_STAT, 32'h0, "R1 status");
    do_read(A_IEN,  32'h0, "R1 mask");

    // R9 reserved mask bits
    do_write(A_IEN, 32'hFFFF_FFFF);
    do_read(A_IEN, 32'h0000_0070, "R9 mask reserved");

    // R3 drop while disabled
    pw_rx_enable = 1'b0;
    send_pw(pa);
    chk(irq, 1'b1, "R10 irq on drop");
    do_read(A_STAT, 32'h0000_0020, "R3 drop flag");
    do_write(A_STAT, 32'h0000_0020);
    chk(irq, 1'b0, "R10 irq after clear");
    do_read(A_STAT, 32'h0, "R7 cleared");

    // R2 accept
    pw_rx_enable = 1'b1;
    send_pw(pa);
    do_read(A_STAT, 32'h0000_0010, "R2 stored flag");
    for (int i = 0; i < WORDS - 1; i++) do_read(A_DATA + 20'(4*i), wd(pa, i), "R2 payload");

    // R4 still full, drop keeps payload
    send_pw(pb);
    do_read(A_STAT, 32'h0000_0030, "R4 drop when full");
    do_read(A_DATA, wd(pa, 0), "R4 payload kept");

    // R5 reading last word frees the store
    do_read(A_DATA + 20'(4*(WORDS-1)), wd(pa, WORDS-1), "R5 last word");
    send_pw(pc);
    do_read(A_DATA, wd(pc, 0), "R5 new payload stored");
    do_read(A_DATA + 20'(4*(WORDS-1)), wd(pc, WORDS-1), "R5 last word new");

    // R11 payload writes ignored, unmapped reads 0
    do_write(A_DATA, 32'hDEAD_BEEF);
    do_read(A_DATA, wd(pc, 0), "R11 payload write ignored");
    do_read(20'h10000, 32'h0, "R11 unmapped");

    do_write(A_STAT, 32'h0000_0030);
    do_read(A_STAT, 32'h0, "R7 clear two");

    // R6 error strobe
    @(negedge clk); pw_err = 1'b1;
    @(negedge clk); pw_err = 1'b0;
    do_read(A_STAT, 32'h0000_0040, "R6 error flag");
    do_write(A_STAT, 32'h0000_0000);
    do_read(A_STAT, 32'h0000_0040, "R7 zero write keeps");

    // R8 set beats clear
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h0000_0040; pw_err = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; pw_err = 1'b0;
    do_read(A_STAT, 32'h0000_0040, "R8 set wins");

    // R10 masking
    do_write(A_IEN, 32'h0);
    chk(irq, 1'b0, "R10 masked");
    do_write(A_IEN, 32'h0000_0040);
    chk(irq, 1'b1, "R10 unmasked");
    do_write(A_IEN, 32'h0000_0020);
    chk(irq, 1'b0, "R10 other mask");

    // R9 reserved status bits ignore writes, all flags clear
    do_write(A_STAT, 32'hFFFF_FFFF);
    do_read(A_STAT, 32'h0, "R9 status reserved");

    @(negedge clk);
    chk(exp_q.size() == 0, 1'b1, "R11 all reads returned");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule